// File: doc/BRIEF.md
# Command Trace Replayer

The replayer walks a read-only memory of fixed-width command words, one word at a time from address zero. Each word starts with a 4-bit opcode. Four opcodes are defined:

- A send word turns its fields into a serial packet on a one-bit valid/ready stream.
- A load word preloads a delay counter.
- A wait word stalls until that counter has run down.
- A done word halts the sequence and raises a done flag.

An opcode outside these four halts the sequence and raises an error flag. The block is used to play a fixed boot or configuration script into a serial configuration network, with timed pauses between packets.

The memory port is combinational: `rom_data_i` must show the word at `rom_addr_o` in the same cycle. The serial output follows valid/ready rules:

- A bit transfers on a rising clock edge when `tx_valid_o` and `tx_ready_i` are both high.
- While valid is high and ready is low, the data and destination outputs hold their values.
- `tx_ready_i` may stay low for any number of cycles. The packet simply stretches.
- `tx_valid_o` is only withdrawn while `en_i` is low.

Driving `en_i` low freezes the whole block, including the address, the counter and the position inside a packet. Work resumes exactly where it stopped.

Top module: `trc_replayer`

## Requirements
- R1: During and right after a synchronous reset, `rom_addr_o` is 0 and `tx_valid_o`, `done_o` and `error_o` are low.
- R2: Command word layout, 20 bits at default parameters. Bits [19:16] hold the opcode. The encodings are 0001 send, 0011 done, 0110 load and 0101 wait. Below the opcode, a send word holds, from most to least significant: a 2-bit destination mask [15:14], a 3-bit client id [13:11], a data-not-reset flag [10], a 3-bit length [9:7] and a 7-bit payload [6:0].
- R3: A send emits one bit per transfer, in this order: a start bit of 1, the data-not-reset flag, the client id with its LSB first, the length with its LSB first, and then the lowest `length` payload bits with the LSB first.
- R4: Each bit transfers only on an edge where valid and ready are both high. While valid is high and ready is low, `tx_data_o` and `tx_dest_o` stay stable.
- R5: `tx_dest_o` equals the send word's mask for every transferred bit and is zero whenever `tx_valid_o` is low.
- R6: A load word copies bits [15:0] into the delay counter in one cycle. A following wait word decrements the counter once per enabled cycle and finishes on the cycle it sees zero. With free flow, a load of N plus a wait leave N+3 idle cycles between two packets.
- R7: After each finished command the address advances by exactly one. Back-to-back sends are separated by one idle cycle.
- R8: On a done word, `done_o` rises, the address stops advancing and no further bits are sent.
- R9: An unrecognised opcode, for example 0000 or 1111, raises `error_o` and halts at that address. It sends nothing more, and `done_o` and `error_o` are never high together.
- R10: While `en_i` is low, `tx_valid_o` is low and the address, the counter and the packet position hold. The bit stream after resuming is identical to an unpaused run.
- R11: A send with length 0 emits only the 8 header bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run enable; low pauses the block |
| rom_addr_o | output | ROM_AW (8) | Address of the current command word |
| rom_data_i | input | WORD_W (20) | Command word at `rom_addr_o`, combinational |
| tx_valid_o | output | 1 | Serial bit valid |
| tx_ready_i | input | 1 | Downstream accepts the serial bit |
| tx_data_o | output | 1 | Serial bit |
| tx_dest_o | output | NUM_MASTERS (2) | Destination mask of the packet being sent |
| done_o | output | 1 | Sequence reached a done word |
| error_o | output | 1 | Sequence hit an unknown opcode |

## Verification
The bench goes after the following corner cases:

- **Field order inside a packet.** A design that sends a field MSB first, or copies payload bits beyond `length`, produces a bit stream that differs from the expected one.
- **Delay timing.** An off-by-one in the wait word shows up as a gap of N+2 or N+4 idle cycles instead of N+3, both with N=5 and with N=0.
- **Ready low and pause.** A design that drops or repeats a bit when ready is low, or that keeps counting while paused, corrupts the stream.
- **Halting.** On a done word or an illegal opcode, a design that keeps advancing the address, or sends a packet after halting, is caught by the final address and bit counts.

// File: rtl/trc_pkg.sv
package trc_pkg;

  typedef enum logic [3:0] {
    OP_SEND = 4'b0001,
    OP_DONE = 4'b0011,
    OP_WAIT = 4'b0101,
    OP_LOAD = 4'b0110
  } trc_op_e;

  typedef enum logic [1:0] {
    ST_EXEC = 2'd0,
    ST_SEND = 2'd1,
    ST_DONE = 2'd2,
    ST_ERR  = 2'd3
  } trc_state_e;

  // ceil(log2(x)), never below one bit
  function automatic int safe_clog2(input int x);
    return (x <= 1) ? 1 : $clog2(x);
  endfunction

endpackage

// File: rtl/trc_field_split.sv
module trc_field_split
  import trc_pkg::*;
#(
  parameter int NUM_MASTERS = 2,
  parameter int CID_W       = 3,
  parameter int LEN_W       = 3,
  parameter int MAX_PAYLOAD = 7,
  localparam int ARG_W      = NUM_MASTERS + CID_W + 1 + LEN_W + MAX_PAYLOAD,
  localparam int WORD_W     = 4 + ARG_W
) (
  input  logic [WORD_W-1:0]      word_i,
  output logic [3:0]             op_o,
  output logic [NUM_MASTERS-1:0] mask_o,
  output logic [CID_W-1:0]       cid_o,
  output logic                   dnr_o,
  output logic [LEN_W-1:0]       len_o,
  output logic [MAX_PAYLOAD-1:0] payload_o,
  output logic [ARG_W-1:0]       delay_o
);
  localparam int PAY_LO  = 0;
  localparam int LEN_LO  = PAY_LO + MAX_PAYLOAD;
  localparam int DNR_LO  = LEN_LO + LEN_W;
  localparam int CID_LO  = DNR_LO + 1;
  localparam int MASK_LO = CID_LO + CID_W;
  localparam int LEN_MAX_CODE = (1 << LEN_W) - 1;

  logic [LEN_W-1:0] len_raw;

  assign op_o      = word_i[WORD_W-1 -: 4];
  assign mask_o    = word_i[MASK_LO +: NUM_MASTERS];
  assign cid_o     = word_i[CID_LO +: CID_W];
  assign dnr_o     = word_i[DNR_LO];
  assign len_raw   = word_i[LEN_LO +: LEN_W];
  assign payload_o = word_i[PAY_LO +: MAX_PAYLOAD];
  assign delay_o   = word_i[ARG_W-1:0];

  // the length code can only exceed the payload when MAX_PAYLOAD+1 is not a power of two
  generate
    if (LEN_MAX_CODE > MAX_PAYLOAD) begin : g_clamp
      assign len_o = (len_raw > LEN_W'(MAX_PAYLOAD)) ? LEN_W'(MAX_PAYLOAD) : len_raw;
    end else begin : g_pass
      assign len_o = len_raw;
    end
  endgenerate

endmodule

// File: rtl/trc_tx_shifter.sv
module trc_tx_shifter #(
  parameter int PKT_W  = 15,
  parameter int BCNT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              load_i,
  input  logic [PKT_W-1:0]  pkt_i,
  input  logic [BCNT_W-1:0] nbits_i,
  input  logic              shift_i,
  output logic              bit_o,
  output logic              last_o
);
  logic [PKT_W-1:0]  sreg_q;
  logic [BCNT_W-1:0] left_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sreg_q <= '0;
      left_q <= '0;
    end else if (load_i) begin
      sreg_q <= pkt_i;
      left_q <= nbits_i;
    end else if (shift_i) begin
      sreg_q <= {1'b0, sreg_q[PKT_W-1:1]};
      left_q <= left_q - BCNT_W'(1);
    end
  end

  assign bit_o  = sreg_q[0];
  assign last_o = (left_q == BCNT_W'(1));

endmodule

// File: rtl/trc_delay_ctr.sv
module trc_delay_ctr #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)       cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/trc_replayer.sv
module trc_replayer
  import trc_pkg::*;
#(
  parameter int NUM_MASTERS = 2,
  parameter int NUM_CLIENTS = 6,
  parameter int MAX_PAYLOAD = 7,
  parameter int ROM_AW      = 8,
  localparam int CID_W      = safe_clog2(NUM_CLIENTS),
  localparam int LEN_W      = safe_clog2(MAX_PAYLOAD + 1),
  localparam int ARG_W      = NUM_MASTERS + CID_W + 1 + LEN_W + MAX_PAYLOAD,
  localparam int WORD_W     = 4 + ARG_W
) (
  input  logic                   clk_i,
  input  logic                   rst_i,
  input  logic                   en_i,
  output logic [ROM_AW-1:0]      rom_addr_o,
  input  logic [WORD_W-1:0]      rom_data_i,
  output logic                   tx_valid_o,
  input  logic                   tx_ready_i,
  output logic                   tx_data_o,
  output logic [NUM_MASTERS-1:0] tx_dest_o,
  output logic                   done_o,
  output logic                   error_o
);
  localparam int HDR_W  = 2 + CID_W + LEN_W;
  localparam int PKT_W  = HDR_W + MAX_PAYLOAD;
  localparam int BCNT_W = $clog2(PKT_W + 1);

  trc_state_e state_q;
  logic [ROM_AW-1:0]      addr_q;
  logic [NUM_MASTERS-1:0] dest_q;

  logic [3:0]             op_w;
  logic [NUM_MASTERS-1:0] mask_w;
  logic [CID_W-1:0]       cid_w;
  logic                   dnr_w;
  logic [LEN_W-1:0]       len_w;
  logic [MAX_PAYLOAD-1:0] pay_w;
  logic [ARG_W-1:0]       delay_w;

  trc_field_split #(
    .NUM_MASTERS(NUM_MASTERS), .CID_W(CID_W), .LEN_W(LEN_W), .MAX_PAYLOAD(MAX_PAYLOAD)
  ) u_split (
    .word_i(rom_data_i), .op_o(op_w), .mask_o(mask_w), .cid_o(cid_w),
    .dnr_o(dnr_w), .len_o(len_w), .payload_o(pay_w), .delay_o(delay_w)
  );

  logic exec_en, is_send, is_load, is_wait, is_done;
  logic cnt_zero, tx_fire, tx_last, advance;
  logic [PKT_W-1:0]  pkt_w;
  logic [BCNT_W-1:0] nbits_w;

  assign exec_en = (state_q == ST_EXEC) && en_i;
  assign is_send = (op_w == OP_SEND);
  assign is_load = (op_w == OP_LOAD);
  assign is_wait = (op_w == OP_WAIT);
  assign is_done = (op_w == OP_DONE);

  assign pkt_w   = {pay_w, len_w, cid_w, dnr_w, 1'b1};
  assign nbits_w = BCNT_W'(HDR_W) + BCNT_W'(len_w);

  assign tx_valid_o = (state_q == ST_SEND) && en_i;
  assign tx_fire    = tx_valid_o && tx_ready_i;

  trc_tx_shifter #(.PKT_W(PKT_W), .BCNT_W(BCNT_W)) u_tx (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(exec_en && is_send),
    .pkt_i(pkt_w), .nbits_i(nbits_w), .shift_i(tx_fire),
    .bit_o(tx_data_o), .last_o(tx_last)
  );

  trc_delay_ctr #(.W(ARG_W)) u_dly (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(exec_en && is_load),
    .val_i(delay_w), .dec_i(exec_en && is_wait), .zero_o(cnt_zero)
  );

  assign advance = (exec_en && (is_load || (is_wait && cnt_zero))) || (tx_fire && tx_last);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= ST_EXEC;
      addr_q  <= '0;
      dest_q  <= '0;
    end else begin
      if (advance) addr_q <= addr_q + ROM_AW'(1);
      case (state_q)
        ST_EXEC: if (en_i) begin
          if (is_send) begin
            state_q <= ST_SEND;
            dest_q  <= mask_w;
          end else if (is_done) begin
            state_q <= ST_DONE;
          end else if (!is_load && !is_wait) begin
            state_q <= ST_ERR;
          end
        end
        ST_SEND: if (tx_fire && tx_last) state_q <= ST_EXEC;
        default: state_q <= state_q;
      endcase
    end
  end

  assign rom_addr_o = addr_q;
  assign tx_dest_o  = tx_valid_o ? dest_q : '0;
  assign done_o     = (state_q == ST_DONE);
  assign error_o    = (state_q == ST_ERR);

endmodule

// File: rtl/trc_replayer_chk.sv
module trc_replayer_chk #(
  parameter int ROM_AW      = 8,
  parameter int NUM_MASTERS = 2
) (
  input logic                   clk_i,
  input logic                   rst_i,
  input logic                   en_i,
  input logic [ROM_AW-1:0]      rom_addr_o,
  input logic                   tx_valid_o,
  input logic                   tx_ready_i,
  input logic                   tx_data_o,
  input logic [NUM_MASTERS-1:0] tx_dest_o,
  input logic                   done_o,
  input logic                   error_o
);
  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (tx_valid_o && !tx_ready_i) |=> (!tx_valid_o || ($stable(tx_data_o) && $stable(tx_dest_o)))); // R4

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(rom_addr_o) |-> (rom_addr_o == $past(rom_addr_o) + ROM_AW'(1))); // R7

  AST_DONE_STICKS: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> (done_o && $stable(rom_addr_o))); // R8

  AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
    (done_o || error_o) |-> !tx_valid_o); // R8

  AST_ERR_STICKS: assert property (@(posedge clk_i) disable iff (rst_i)
    error_o |=> (error_o && $stable(rom_addr_o))); // R9

  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (rst_i)
    !(done_o && error_o)); // R9

  AST_PAUSE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> $stable(rom_addr_o)); // R10

endmodule

bind trc_replayer trc_replayer_chk #(.ROM_AW(ROM_AW), .NUM_MASTERS(NUM_MASTERS)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i), .rom_addr_o(rom_addr_o),
  .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o),
  .tx_dest_o(tx_dest_o), .done_o(done_o), .error_o(error_o)
);

// File: tb/sim_trc_replayer.sv
`timescale 1ns/1ps
module sim_trc_replayer;
  import trc_pkg::*;

  localparam int NM     = 2;
  localparam int NC     = 6;
  localparam int MP     = 7;
  localparam int AW     = 8;
  localparam int CID_W  = safe_clog2(NC);
  localparam int LEN_W  = safe_clog2(MP + 1);
  localparam int ARG_W  = NM + CID_W + 1 + LEN_W + MP;
  localparam int WORD_W = 4 + ARG_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b1;
  logic ready = 1'b1;
  logic [AW-1:0] rom_addr;
  logic [WORD_W-1:0] rom_data;
  logic tx_valid, tx_data, done, error;
  logic [NM-1:0] tx_dest;
  logic [WORD_W-1:0] rom [0:255];

  always #10 clk = ~clk;  // 50 MHz

  assign rom_data = rom[rom_addr];

  trc_replayer #(.NUM_MASTERS(NM), .NUM_CLIENTS(NC), .MAX_PAYLOAD(MP), .ROM_AW(AW)) u0 (
    .clk_i(clk), .rst_i(rst), .en_i(en), .rom_addr_o(rom_addr), .rom_data_i(rom_data),
    .tx_valid_o(tx_valid), .tx_ready_i(ready), .tx_data_o(tx_data), .tx_dest_o(tx_dest),
    .done_o(done), .error_o(error)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit exp_q[$];
  bit got_q[$];
  logic [NM-1:0] exp_dest[$];
  logic [NM-1:0] got_dest[$];
  int gaps[$];
  int gap_cnt = 0;
  bit seen_pkt = 0;
  int dest_idle_bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: sampled away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (tx_valid) begin
        if (gap_cnt > 0 && seen_pkt) gaps.push_back(gap_cnt);
        gap_cnt = 0;
        seen_pkt = 1;
        if (ready) begin
          got_q.push_back(tx_data);
          got_dest.push_back(tx_dest);
        end
      end else begin
        gap_cnt++;
        if (tx_dest != '0) dest_idle_bad++;
      end
    end
  end

  function automatic logic [WORD_W-1:0] w_send(input int mask, input int cid, input bit dnr,
                                               input int len, input int pay);
    return {4'b0001, NM'(mask), CID_W'(cid), dnr, LEN_W'(len), MP'(pay)};
  endfunction
  function automatic logic [WORD_W-1:0] w_load(input int n);
    return {4'b0110, ARG_W'(n)};
  endfunction
  function automatic logic [WORD_W-1:0] w_wait();
    return {4'b0101, ARG_W'(0)};
  endfunction
  function automatic logic [WORD_W-1:0] w_done();
    return {4'b0011, ARG_W'(0)};
  endfunction

  // expected serial image of a send, built from R3
  task automatic expect_pkt(input int mask, input int cid, input bit dnr, input int len, input int pay);
    exp_q.push_back(1'b1);
    exp_q.push_back(dnr);
    for (int i = 0; i < CID_W; i++) exp_q.push_back(cid[i]);
    for (int i = 0; i < LEN_W; i++) exp_q.push_back(len[i]);
    for (int i = 0; i < len; i++) exp_q.push_back(pay[i]);
    for (int i = 0; i < 2 + CID_W + LEN_W + len; i++) exp_dest.push_back(NM'(mask));
  endtask

  task automatic fresh(input logic en_v, input logic rdy_v);
    @(posedge clk); #1;
    rst = 1'b1; en = en_v; ready = rdy_v;
    for (int i = 0; i < 256; i++) rom[i] = w_done();
    exp_q.delete(); got_q.delete(); exp_dest.delete(); got_dest.delete(); gaps.delete();
    gap_cnt = 0; seen_pkt = 0; dest_idle_bad = 0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  // mode 0 free flow, 1 random ready, 2 random enable
  task automatic run_prog(input int mode, input string req);
    logic [7:0] lf = 8'h5B;
    int cyc = 0;
    while (!(done || error) && cyc < 3000) begin
      @(posedge clk); #1;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      ready = (mode == 1) ? (lf[0] | lf[2]) : 1'b1;
      en    = (mode == 2) ? (lf[1] | lf[4]) : 1'b1;
      @(negedge clk);
      cyc++;
    end
    #1 ready = 1'b1; en = 1'b1;
    check(cyc < 3000, req, "run finished before limit (cycles)", cyc, 3000);
  endtask

  task automatic cmp_stream(input string req);
    int mm = 0;
    check(got_q.size() == exp_q.size(), req, "bit count", got_q.size(), exp_q.size());
    if (got_q.size() == exp_q.size())
      for (int i = 0; i < got_q.size(); i++)
        if (got_q[i] != exp_q[i] || got_dest[i] != exp_dest[i]) mm++;
    check(mm == 0, req, "mismatching bits/dest", mm, 0);
  endtask

  task automatic t_reset();
    @(posedge clk); #1 rst = 1'b1;
    @(negedge clk);
    check(rom_addr == 0, "R1", "addr in reset", rom_addr, 0);
    check({tx_valid, done, error} == 3'b000, "R1", "valid/done/error in reset", {tx_valid, done, error}, 0);
    fresh(1'b0, 1'b1);
    @(negedge clk);
    check(rom_addr == 0 && !tx_valid, "R1", "addr after reset", rom_addr, 0);
  endtask

  task automatic t_basic();
    fresh(1'b1, 1'b1);
    rom[0] = w_send(1, 5, 1, 7, 'h5A); expect_pkt(1, 5, 1, 7, 'h5A);
    rom[1] = w_send(2, 2, 0, 3, 'h7D); expect_pkt(2, 2, 0, 3, 'h7D);
    rom[2] = w_done();
    run_prog(0, "R3");
    cmp_stream("R3");  // also checks R2 field positions and R5 destinations
    check(gaps.size() == 1 && gaps[0] == 1, "R7", "gap between back-to-back sends", (gaps.size() > 0) ? gaps[0] : -1, 1);
    check(dest_idle_bad == 0, "R5", "dest nonzero while idle", dest_idle_bad, 0);
    check(done && !error, "R8", "done flag", done, 1);
    repeat (5) @(negedge clk);
    check(rom_addr == 2, "R8", "address held at done word", rom_addr, 2);
    check(got_q.size() == exp_q.size(), "R8", "no bits after done", got_q.size(), exp_q.size());
  endtask

  task automatic t_zero_len();
    fresh(1'b1, 1'b1);
    rom[0] = w_send(3, 4, 0, 0, 'h7F); expect_pkt(3, 4, 0, 0, 'h7F);
    rom[1] = w_done();
    run_prog(0, "R11");
    check(got_q.size() == 8, "R11", "zero-length packet bits", got_q.size(), 8);
    cmp_stream("R11");
  endtask

  task automatic t_wait();
    fresh(1'b1, 1'b1);
    rom[0] = w_send(1, 1, 1, 2, 'h03); expect_pkt(1, 1, 1, 2, 'h03);
    rom[1] = w_load(5);
    rom[2] = w_wait();
    rom[3] = w_send(2, 3, 0, 1, 'h01); expect_pkt(2, 3, 0, 1, 'h01);
    rom[4] = w_load(0);
    rom[5] = w_wait();
    rom[6] = w_send(1, 0, 1, 4, 'h0A); expect_pkt(1, 0, 1, 4, 'h0A);
    rom[7] = w_done();
    run_prog(0, "R6");
    cmp_stream("R6");
    check(gaps.size() == 2 && gaps[0] == 8, "R6", "idle cycles after delay 5", (gaps.size() > 0) ? gaps[0] : -1, 8);
    check(gaps.size() == 2 && gaps[1] == 3, "R6", "idle cycles after delay 0", (gaps.size() > 1) ? gaps[1] : -1, 3);
    check(rom_addr == 7, "R7", "final address", rom_addr, 7);
  endtask

  task automatic t_backpressure();
    fresh(1'b1, 1'b0);
    rom[0] = w_send(2, 5, 1, 6, 'h2B); expect_pkt(2, 5, 1, 6, 'h2B);
    rom[1] = w_send(1, 1, 0, 7, 'h55); expect_pkt(1, 1, 0, 7, 'h55);
    rom[2] = w_done();
    run_prog(1, "R4");
    cmp_stream("R4");
  endtask

  task automatic t_pause();
    fresh(1'b0, 1'b1);
    rom[0] = w_send(1, 6, 1, 5, 'h13); expect_pkt(1, 6, 1, 5, 'h13);
    rom[1] = w_load(4);
    rom[2] = w_wait();
    rom[3] = w_send(2, 2, 0, 7, 'h6C); expect_pkt(2, 2, 0, 7, 'h6C);
    rom[4] = w_done();
    repeat (4) @(negedge clk);
    check(rom_addr == 0 && !tx_valid && got_q.size() == 0, "R10", "held while disabled (addr)", rom_addr, 0);
    run_prog(2, "R10");
    cmp_stream("R10");
    check(rom_addr == 4 && done, "R10", "final address after pauses", rom_addr, 4);
  endtask

  task automatic t_error();
    fresh(1'b1, 1'b1);
    rom[0] = w_send(1, 2, 1, 1, 'h01); expect_pkt(1, 2, 1, 1, 'h01);
    rom[1] = {4'b1111, ARG_W'(0)};
    rom[2] = w_send(2, 3, 1, 3, 'h07);
    run_prog(0, "R9");
    repeat (4) @(negedge clk);
    check(error && !done, "R9", "error flag on opcode 1111", error, 1);
    check(rom_addr == 1, "R9", "address held at bad word", rom_addr, 1);
    cmp_stream("R9");
    fresh(1'b1, 1'b1);
    rom[0] = '0;
    run_prog(0, "R9");
    check(error && rom_addr == 0 && got_q.size() == 0, "R9", "opcode 0000 halts at address", rom_addr, 0);
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) rom[i] = w_done();
    t_reset();
    t_basic();
    t_zero_len();
    t_wait();
    t_backpressure();
    t_pause();
    t_error();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule